// File: doc/BRIEF.md
# Dual-Channel Stream Health Monitor

This block watches two incoming streams of time-stamped measurement messages and turns the per-message strobes into status flags. The flags change only at processing-interval boundaries. A single-cycle `tick` input marks each boundary. Between two ticks, each channel can present message-valid strobes carrying a sequence number, and alignment-done strobes. At the next tick these events become flags, and each flag then holds for exactly one interval.

For each channel the monitor reports four things:
- whether a message arrived during the interval;
- whether the channel's data became aligned;
- whether the most recent message is older than a programmable age limit;
- whether the messages of the interval continued the sequence without a gap.

A combined flag reports that every enabled channel was aligned in the same interval. Each channel's 16 digital payload bits appear at the output only while that channel's aligned flag is high, and are zero otherwise. Downstream logic uses the flags to decide whether the remote data may be used.

Top module: `stream_health_monitor`

## Requirements
- R1: The receipt flag of a channel (bit 0 = channel A, bit 1 = channel B) updates only at a tick. It is high for the tick period after a tick exactly when a message-valid strobe occurred on that channel since the previous tick, including the tick cycle itself.
- R2: A channel's aligned flag updates only at a tick. It is high for the following tick period exactly when an alignment-done strobe occurred on that channel since the previous tick.
- R3: The combined aligned flag updates at a tick. It is high for the following tick period only when at least one channel is enabled and every enabled channel's aligned flag is high after that tick. Disabled channels are ignored.
- R4: A per-channel age counter clears to zero on every valid message, counts ticks otherwise, and saturates at 2^AGE_W-1. The stale flag is high while the age is strictly greater than `max_delay`. The age is zero after reset.
- R5: At a tick following one or more messages on a channel, the in-sequence flag becomes 1 when every message of the interval carried the previous accepted number plus one, modulo 2^16. Otherwise it becomes 0. Without messages the flag holds its value, and it is 0 after reset.
- R6: The first message after reset, or after `cfg_ok` of that channel was low, counts as in sequence whatever its number.
- R7: The gated payload of a channel equals its payload input while that channel's aligned flag is high, and is zero otherwise.
- R8: The configured flag of a channel is `cfg_ok` delayed by one clock, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Processing-interval boundary strobe |
| max_delay | input | AGE_W | Age limit in ticks |
| cfg_ok | input | NUM_CH | Per-channel configured indication |
| ch_en | input | NUM_CH | Per-channel enable for the combined check |
| msg_valid | input | NUM_CH | Per-channel valid-message strobe |
| seq_num | input | NUM_CH*SEQ_W | Sequence numbers, channel 0 in the low bits |
| align_done | input | NUM_CH | Per-channel alignment-done strobe |
| payload | input | NUM_CH*DIG_W | Received digital bits, channel 0 in the low bits |
| rx_flag | output | NUM_CH | Message received in last interval |
| aligned_flag | output | NUM_CH | Channel aligned in last interval |
| all_aligned | output | 1 | All enabled channels aligned |
| stale_flag | output | NUM_CH | Last message older than the limit |
| in_seq_flag | output | NUM_CH | No sequence gap in last processed messages |
| configured_flag | output | NUM_CH | Registered configured indication |
| gated_payload | output | NUM_CH*DIG_W | Payload shown only while aligned |

## Verification
The main vector walk tries several mixes of events in each interval: both channels, channel A only, channel B only, or neither, each with different enable masks. Comparing the combined flag with the per-channel flags separates a missing enable mask from an AND taken over all channels, and shows that a zero mask never reports alignment. Sequence patterns include an in-order step, a skipped number, a repeated number, a wrap from 0xFFFF to 0, and a gap hidden between two messages of a single interval; together they distinguish checking only the last message from checking every message. Long idle runs with the age limit at and one below the saturation value show whether the counter saturates or wraps, and whether the compare is strict.

// File: rtl/shm_pkg.sv
package shm_pkg;
   localparam int unsigned SHM_DEF_SEQ_W = 16;
   localparam int unsigned SHM_DEF_DIG_W = 16;

   typedef struct packed {
      logic rx;
      logic aligned;
      logic aligned_nxt;
      logic stale;
      logic in_seq;
      logic configured;
   } shm_status_t;
endpackage

// File: rtl/shm_event_latch.sv
module shm_event_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ev,
   output logic flag_nxt,
   output logic flag
);
   logic pend_q;

   assign flag_nxt = pend_q | ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         flag   <= 1'b0;
      end else if (tick) begin
         flag   <= flag_nxt;
         pend_q <= 1'b0;
      end else if (ev) begin
         pend_q <= 1'b1;
      end
   end

   AST_FLAG_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(flag)); // R1
   AST_EVENT_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ev) |=> flag); // R2
endmodule

// File: rtl/shm_age_timer.sv
module shm_age_timer #(
   parameter int unsigned AGE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             msg,
   input  logic [AGE_W-1:0] max_delay,
   output logic             stale
);
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       age_q <= '0;
      else if (msg)                     age_q <= '0;
      else if (tick && age_q != AGE_MAX) age_q <= age_q + 1'b1;
   end

   assign stale = age_q > max_delay;

   AST_FRESH_AFTER_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      msg |=> !stale); // R4
   AST_AGE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == AGE_MAX && !msg) |=> age_q == AGE_MAX); // R4
endmodule

// File: rtl/shm_seq_check.sv
module shm_seq_check #(
   parameter int unsigned SEQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cfg_ok,
   input  logic             msg,
   input  logic [SEQ_W-1:0] seq,
   output logic             in_seq
);
   logic             have_prev_q;
   logic [SEQ_W-1:0] last_q;
   logic             pend_msg_q;
   logic             pend_ok_q;
   logic             match;

   assign match = !have_prev_q || (seq == last_q + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev_q <= 1'b0;
         last_q      <= '0;
      end else if (!cfg_ok) begin
         have_prev_q <= 1'b0;
      end else if (msg) begin
         have_prev_q <= 1'b1;
         last_q      <= seq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_msg_q <= 1'b0;
         pend_ok_q  <= 1'b1;
         in_seq     <= 1'b0;
      end else if (tick) begin
         if (pend_msg_q || msg) in_seq <= pend_ok_q & (!msg || match);
         pend_msg_q <= 1'b0;
         pend_ok_q  <= 1'b1;
      end else if (msg) begin
         pend_msg_q <= 1'b1;
         pend_ok_q  <= pend_ok_q & match;
      end
   end

   AST_SEQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && msg && cfg_ok && have_prev_q && seq != last_q + 1'b1) |=> !in_seq); // R5
   AST_SEQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && msg && !have_prev_q && !pend_msg_q) |=> in_seq); // R6
endmodule

// File: rtl/shm_channel.sv
module shm_channel
   import shm_pkg::*;
#(
   parameter int unsigned SEQ_W        = SHM_DEF_SEQ_W,
   parameter int unsigned DIG_W        = SHM_DEF_DIG_W,
   parameter int unsigned AGE_W        = 8,
   parameter bit          HOLD_PAYLOAD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [AGE_W-1:0] max_delay,
   input  logic             cfg_ok,
   input  logic             msg,
   input  logic [SEQ_W-1:0] seq,
   input  logic             align,
   input  logic [DIG_W-1:0] dig_in,
   output shm_status_t      status,
   output logic [DIG_W-1:0] dig_out
);
   logic rx_nxt, al_nxt, rx_q, al_q, stale, in_seq, cfg_q;

   shm_event_latch u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ev(msg),
      .flag_nxt(rx_nxt), .flag(rx_q));

   shm_event_latch u_align (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ev(align),
      .flag_nxt(al_nxt), .flag(al_q));

   shm_age_timer #(.AGE_W(AGE_W)) u_age (
      .clk(clk), .rst_n(rst_n), .tick(tick), .msg(msg),
      .max_delay(max_delay), .stale(stale));

   shm_seq_check #(.SEQ_W(SEQ_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_ok(cfg_ok),
      .msg(msg), .seq(seq), .in_seq(in_seq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= 1'b0;
      else        cfg_q <= cfg_ok;
   end

   generate
      if (HOLD_PAYLOAD) begin : g_hold
         logic [DIG_W-1:0] cap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cap_q <= '0;
            else if (tick)             cap_q <= al_nxt ? dig_in : '0;
         end
         assign dig_out = cap_q;
      end else begin : g_live
         assign dig_out = al_q ? dig_in : '0;
      end
   endgenerate

   assign status.rx          = rx_q;
   assign status.aligned     = al_q;
   assign status.aligned_nxt = al_nxt;
   assign status.stale       = stale;
   assign status.in_seq      = in_seq;
   assign status.configured  = cfg_q;

   AST_CFG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ok |=> status.configured); // R8
   AST_GATE_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_out != '0) |-> (HOLD_PAYLOAD || al_q)); // R7
endmodule

// File: rtl/stream_health_monitor.sv
module stream_health_monitor
   import shm_pkg::*;
#(
   parameter int unsigned NUM_CH       = 2,
   parameter int unsigned SEQ_W        = SHM_DEF_SEQ_W,
   parameter int unsigned DIG_W        = SHM_DEF_DIG_W,
   parameter int unsigned AGE_W        = 8,
   parameter bit          HOLD_PAYLOAD = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [AGE_W-1:0]        max_delay,
   input  logic [NUM_CH-1:0]       cfg_ok,
   input  logic [NUM_CH-1:0]       ch_en,
   input  logic [NUM_CH-1:0]       msg_valid,
   input  logic [NUM_CH*SEQ_W-1:0] seq_num,
   input  logic [NUM_CH-1:0]       align_done,
   input  logic [NUM_CH*DIG_W-1:0] payload,
   output logic [NUM_CH-1:0]       rx_flag,
   output logic [NUM_CH-1:0]       aligned_flag,
   output logic                    all_aligned,
   output logic [NUM_CH-1:0]       stale_flag,
   output logic [NUM_CH-1:0]       in_seq_flag,
   output logic [NUM_CH-1:0]       configured_flag,
   output logic [NUM_CH*DIG_W-1:0] gated_payload
);
   initial begin
      assert (NUM_CH >= 1) else $error("NUM_CH must be at least 1");
      assert (SEQ_W >= 2)  else $error("SEQ_W must be at least 2");
      assert (DIG_W >= 1)  else $error("DIG_W must be at least 1");
      assert (AGE_W >= 1 && AGE_W <= 32) else $error("AGE_W out of range");
   end

   shm_status_t        st [NUM_CH];
   logic [NUM_CH-1:0]  al_nxt;
   logic               all_q;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         shm_channel #(
            .SEQ_W(SEQ_W), .DIG_W(DIG_W), .AGE_W(AGE_W),
            .HOLD_PAYLOAD(HOLD_PAYLOAD)
         ) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .max_delay(max_delay),
            .cfg_ok(cfg_ok[c]), .msg(msg_valid[c]),
            .seq(seq_num[c*SEQ_W +: SEQ_W]), .align(align_done[c]),
            .dig_in(payload[c*DIG_W +: DIG_W]),
            .status(st[c]), .dig_out(gated_payload[c*DIG_W +: DIG_W]));

         assign rx_flag[c]         = st[c].rx;
         assign aligned_flag[c]    = st[c].aligned;
         assign al_nxt[c]          = st[c].aligned_nxt;
         assign stale_flag[c]      = st[c].stale;
         assign in_seq_flag[c]     = st[c].in_seq;
         assign configured_flag[c] = st[c].configured;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    all_q <= 1'b0;
      else if (tick) all_q <= (|ch_en) && (&(al_nxt | ~ch_en));
   end

   assign all_aligned = all_q;

   AST_ALL_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ch_en == '0) |=> !all_aligned); // R3
   AST_ALL_IMPLIES_EACH: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!all_aligned || ((aligned_flag & $past(ch_en)) == $past(ch_en)))); // R3
endmodule

// File: tb/tb_stream_health_monitor.sv
module tb_stream_health_monitor;
   localparam int NCH = 2;
   localparam int SW  = 16;
   localparam int DW  = 16;
   localparam int AW  = 8;
   localparam logic [DW-1:0] PAY_A = 16'hA5A5;
   localparam logic [DW-1:0] PAY_B = 16'h3C3C;

   typedef struct packed {
      logic [1:0]  msg;
      logic [15:0] sa;
      logic [15:0] sb;
      logic [1:0]  aln;
      logic [1:0]  en;
      logic [1:0]  x_rx;
      logic [1:0]  x_al;
      logic        x_all;
      logic [1:0]  x_stale;
      logic [1:0]  x_seq;
   } vec_t;

   // max_delay = 2 throughout the walk; bit0 = channel A, bit1 = channel B
   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{2'b11, 16'd10, 16'd100, 2'b00, 2'b11, 2'b11, 2'b00, 1'b0, 2'b00, 2'b11},
      '{2'b11, 16'd11, 16'd101, 2'b11, 2'b11, 2'b11, 2'b11, 1'b1, 2'b00, 2'b11},
      '{2'b01, 16'd13, 16'd0,   2'b01, 2'b11, 2'b01, 2'b01, 1'b0, 2'b00, 2'b10},
      '{2'b00, 16'd0,  16'd0,   2'b01, 2'b01, 2'b00, 2'b01, 1'b1, 2'b10, 2'b10},
      '{2'b01, 16'd14, 16'd0,   2'b00, 2'b01, 2'b01, 2'b00, 1'b0, 2'b10, 2'b11},
      '{2'b10, 16'd0,  16'd102, 2'b10, 2'b10, 2'b10, 2'b10, 1'b1, 2'b00, 2'b11},
      '{2'b00, 16'd0,  16'd0,   2'b00, 2'b11, 2'b00, 2'b00, 1'b0, 2'b01, 2'b11},
      '{2'b11, 16'd15, 16'd102, 2'b10, 2'b11, 2'b11, 2'b10, 1'b0, 2'b00, 2'b01},
      '{2'b00, 16'd0,  16'd0,   2'b11, 2'b00, 2'b00, 2'b11, 1'b0, 2'b00, 2'b01}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [AW-1:0] max_delay = 8'd2;
   logic [NCH-1:0] cfg_ok = 2'b11;
   logic [NCH-1:0] ch_en = 2'b11;
   logic [NCH-1:0] msg_valid = '0;
   logic [NCH*SW-1:0] seq_num = '0;
   logic [NCH-1:0] align_done = '0;
   logic [NCH*DW-1:0] payload = {PAY_B, PAY_A};
   logic [NCH-1:0] rx_flag, aligned_flag, stale_flag, in_seq_flag, configured_flag;
   logic all_aligned;
   logic [NCH*DW-1:0] gated_payload;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   stream_health_monitor #(.NUM_CH(NCH), .SEQ_W(SW), .DIG_W(DW), .AGE_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .max_delay(max_delay),
      .cfg_ok(cfg_ok), .ch_en(ch_en), .msg_valid(msg_valid), .seq_num(seq_num),
      .align_done(align_done), .payload(payload), .rx_flag(rx_flag),
      .aligned_flag(aligned_flag), .all_aligned(all_aligned), .stale_flag(stale_flag),
      .in_seq_flag(in_seq_flag), .configured_flag(configured_flag),
      .gated_payload(gated_payload));

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // one strobe cycle, then a tick cycle, then sample after the tick edge
   task automatic interval(logic [1:0] m, logic [15:0] sa, logic [15:0] sb, logic [1:0] al);
      msg_valid = m; seq_num = {sb, sa}; align_done = al;
      @(negedge clk);
      msg_valid = '0; align_done = '0; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle_ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset rx", rx_flag, 0);
      check("R2 reset aligned", aligned_flag, 0);
      check("R3 reset all", all_aligned, 0);
      check("R5 reset in_seq", in_seq_flag, 0);
      check("R8 configured in reset", configured_flag, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 configured after cfg", configured_flag, 2'b11);
      check("R4 fresh after reset", stale_flag, 0);

      for (int v = 0; v < NV; v++) begin
         ch_en = VEC[v].en;
         interval(VEC[v].msg, VEC[v].sa, VEC[v].sb, VEC[v].aln);
         check($sformatf("R1 rx v%0d", v), rx_flag, VEC[v].x_rx);
         check($sformatf("R2 aligned v%0d", v), aligned_flag, VEC[v].x_al);
         check($sformatf("R3 all v%0d", v), all_aligned, VEC[v].x_all);
         check($sformatf("R4 stale v%0d", v), stale_flag, VEC[v].x_stale);
         check($sformatf("R5 seq v%0d", v), in_seq_flag, VEC[v].x_seq);
         check($sformatf("R7 gated v%0d", v), gated_payload,
               {VEC[v].x_al[1] ? PAY_B : 16'h0, VEC[v].x_al[0] ? PAY_A : 16'h0});
      end
      ch_en = 2'b11;

      // R5: wrap 0xFFFF -> 0x0000 on channel A (last accepted was 15)
      interval(2'b01, 16'hFFFF, 16'd0, 2'b00);
      check("R5 jump to FFFF", in_seq_flag[0], 1'b0);
      interval(2'b01, 16'h0000, 16'd0, 2'b00);
      check("R5 wrap to 0000", in_seq_flag[0], 1'b1);

      // R5: gap between two messages of one interval (1 then 3)
      msg_valid = 2'b01; seq_num = {16'd0, 16'd1}; @(negedge clk);
      msg_valid = 2'b01; seq_num = {16'd0, 16'd3}; @(negedge clk);
      msg_valid = 2'b00; tick = 1'b1; @(negedge clk); tick = 1'b0;
      check("R5 hidden gap", in_seq_flag[0], 1'b0);
      check("R1 rx after burst", rx_flag, 2'b01);
      idle_ticks(1);
      check("R5 hold without message", in_seq_flag[0], 1'b0);
      check("R1 rx drops after one interval", rx_flag, 2'b00);

      // R6 / R8: dropping cfg_ok restarts the sequence check
      cfg_ok = 2'b10; @(negedge clk);
      check("R8 configured follows low", configured_flag, 2'b10);
      cfg_ok = 2'b11;
      interval(2'b01, 16'd500, 16'd0, 2'b00);
      check("R6 first after reconfig", in_seq_flag[0], 1'b1);

      // R4: saturation and strict compare
      max_delay = 8'hFF;
      idle_ticks(300);
      check("R4 saturated not above FF", stale_flag, 2'b00);
      max_delay = 8'hFE; #1;
      check("R4 saturated above FE", stale_flag, 2'b11);
      interval(2'b10, 16'd0, 16'd7, 2'b00);
      check("R4 message clears B age", stale_flag, 2'b01);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule